// File: doc/BRIEF.md
# ADC Conversion Data Serial Readout

This block is the data-output side of a converter's serial slave port. Each completed conversion arrives as a one-cycle strobe with a 32-bit word. The block latches the word and pulls an active-low data-ready line. The host then lowers chip select and clocks the word out most significant bit first, with no command needed. The host samples on the rising serial-clock edge, and the block advances its output on the falling edge. Once the word is exhausted, the line shows zeros. While chip select is high, the output driver is released.

Three things guard a read in progress. A result that arrives early in a read is thrown away. One that arrives after three bytes have gone out is parked and presented when chip select rises. The block also watches the host's data input during the read. If that input carries a complete read-data or read-register opcode byte, the stream stops and a one-cycle command-pending pulse goes out. A separate reload input restores the last word for a repeat read. All logic runs on the system clock. The serial clock, chip select and data input are synchronized first, so the serial clock must stay at or below a quarter of the system clock.

Top module: `conv_readout`

## Requirements
- R1: While cs_n is high, dout_en is 0 (output released). In the same instant that cs_n goes low, dout_en is 1 and dout shows bit 31 of the held word, before any sclk edge.
- R2: dout changes only in response to a falling sclk edge while the frame is open, so the value sampled at each rising edge is the next bit of the word.
- R3: drdy_n goes to 0 in the cycle after conv_valid loads a word while no frame is open. It returns to 1 after the first falling sclk edge of the next frame.
- R4: A frame shifts the 32-bit word out MSB first. Every further sclk cycle in that frame shows dout = 0.
- R5: A conv_valid that arrives during a frame with fewer than 24 bits already shifted is discarded. The current read is not disturbed, and drdy_n stays 1 after the frame.
- R6: A conv_valid that arrives during a frame with 24 or more bits shifted is kept. The current read completes unchanged. When cs_n rises, the kept word becomes the held word and drdy_n goes to 0.
- R7: A data-input byte, captured MSB first on rising sclk edges from the start of the frame, raises cmd_pend for exactly one clock if it equals 8'h12 (read-data) or has upper three bits 3'b001 (read-register, 8'h20 to 8'h3F). After that, dout is 0 for the rest of the frame. Any other byte, such as 8'hA5, has no effect on cmd_pend or dout.
- R8: A reload_req pulse restores the last held word to the output and restarts the bit count. It does not change drdy_n.
- R9: A word is returned once by a direct read. A later frame, without a new word or a reload, reads all zeros.
- R10: Raising cs_n partway through a frame ends it and clears the bit count. After a reload, the next frame again starts from bit 31.
- R11: After reset, drdy_n = 1 and cmd_pend = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: new conversion result present |
| conv_word | input | 32 | Conversion result accompanying conv_valid |
| reload_req | input | 1 | Restore the last held word for a repeat read |
| sclk | input | 1 | Host serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Host serial data input, watched for opcodes |
| dout | output | 1 | Serial data output value |
| dout_en | output | 1 | Output driver enable; 0 means high impedance |
| drdy_n | output | 1 | Active-low data ready |
| cmd_pend | output | 1 | One-cycle pulse: read opcode seen during output |

## Verification
The hardest case is a new result arriving in the middle of a read, right at the three-byte boundary. The result must land after exactly 23 or exactly 24 falling edges have been processed, and while chip select is still low. The bench clocks a chosen number of bits, pauses with the frame open, pulses the conversion strobe, and then finishes the frame. It does this for both directed counts and for random counts from 1 to 31. The opcode abort is reached the same way, by driving the opcode as the first byte on the data input during a full read.

// File: rtl/rd_pkg.sv
package rd_pkg;
  // True when a captured byte is one of the two read opcodes
  function automatic logic opcode_hit(input logic [7:0] b,
                                      input logic [7:0] rdata_op,
                                      input logic [7:0] rreg_val,
                                      input logic [7:0] rreg_mask);
    return (b == rdata_op) || ((b & rreg_mask) == rreg_val);
  endfunction

  // True when enough bits are out that a newer result may be kept
  function automatic logic keep_new(input logic [31:0] shifted,
                                    input logic [31:0] keep_bits);
    return shifted >= keep_bits;
  endfunction
endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign lvl[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/rd_cmd_sniff.sv
module rd_cmd_sniff
  import rd_pkg::*;
#(
  parameter logic [7:0] RDATA_OP  = 8'h12,
  parameter logic [7:0] RREG_VAL  = 8'h20,
  parameter logic [7:0] RREG_MASK = 8'hE0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_frame,
  input  logic sclk_rise,
  input  logic din_s,
  output logic cmd_hit
);
  logic [6:0] part;
  logic [2:0] nbit;
  logic       byte_done;
  logic [7:0] next_byte;

  assign next_byte = {part, din_s};
  assign byte_done = in_frame && sclk_rise && (nbit == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part    <= '0;
      nbit    <= '0;
      cmd_hit <= 1'b0;
    end else begin
      cmd_hit <= byte_done && opcode_hit(next_byte, RDATA_OP, RREG_VAL, RREG_MASK);
      if (!in_frame) begin
        nbit <= '0;
      end else if (sclk_rise) begin
        part <= next_byte[6:0];
        nbit <= nbit + 3'd1;
      end
    end
  end

  // R7: the command flag is a single-clock pulse
  assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> !cmd_hit);
endmodule

// File: rtl/rd_word_path.sv
module rd_word_path
  import rd_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int KEEP_BITS = 24,
  localparam int CNT_W    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_frame,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              reload_req,
  input  logic              abort,
  output logic              dout_bit,
  output logic              drdy_n
);
  logic [WORD_W-1:0] held, shreg, pend;
  logic              pend_v;
  logic [CNT_W-1:0]  bit_cnt;
  logic              late_ok;
  logic              word_done;

  assign late_ok   = keep_new(32'(bit_cnt), 32'(KEEP_BITS));
  assign word_done = (bit_cnt == CNT_W'(WORD_W));
  assign dout_bit  = shreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      shreg   <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
      bit_cnt <= '0;
      drdy_n  <= 1'b1;
    end else begin
      if (in_frame) begin
        if (sclk_fall) begin
          drdy_n <= 1'b1;
          if (!word_done) begin
            shreg   <= {shreg[WORD_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (conv_valid && late_ok) begin
          pend   <= conv_word;
          pend_v <= 1'b1;
        end
      end else begin
        bit_cnt <= '0;
        if (cs_rise) begin
          pend_v <= 1'b0;
          if (pend_v) begin
            held   <= pend;
            shreg  <= pend;
            drdy_n <= 1'b0;
          end else if (bit_cnt != '0) begin
            shreg <= '0;
          end
        end
        if (conv_valid) begin
          held   <= conv_word;
          shreg  <= conv_word;
          drdy_n <= 1'b0;
        end
      end
      if (abort) shreg <= '0;
      if (reload_req) begin
        shreg   <= held;
        bit_cnt <= '0;
      end
    end
  end

  // R2: output word only moves on a falling serial edge inside a frame
  assert_shift_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !sclk_fall && !abort && !reload_req) |=> $stable(shreg));
  // R3: first falling edge of a frame releases data-ready
  assert_drdy_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && sclk_fall) |=> drdy_n);
  // R4: once the whole word is out, only zeros remain
  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && word_done) |-> (shreg == '0));
  // R5: an early result leaves the parked word untouched
  assert_drop_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && conv_valid && !late_ok) |=> ($stable(pend) && $stable(pend_v)));
  // R6: a late result is parked
  assert_keep_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && conv_valid && late_ok) |=> (pend_v && pend == $past(conv_word)));
  // R6: parked word is presented when the frame closes
  assert_promote_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && pend_v && !conv_valid && !reload_req && !abort) |=>
      (!drdy_n && shreg == $past(pend)));
  // R8: reload restores the held word
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> (shreg == $past(held) && bit_cnt == '0));
endmodule

// File: rtl/conv_readout.sv
module conv_readout #(
  parameter int         WORD_W    = 32,
  parameter int         KEEP_BITS = 24,
  parameter logic [7:0] RDATA_OP  = 8'h12,
  parameter logic [7:0] RREG_VAL  = 8'h20,
  parameter logic [7:0] RREG_MASK = 8'hE0,
  parameter int         SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              reload_req,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  output logic              drdy_n,
  output logic              cmd_pend
);
  logic [2:0] raw_in, sync_out;
  logic       sclk_s, cs_s, din_s;
  logic       sclk_d, cs_d;
  logic       sclk_rise, sclk_fall, cs_rise, in_frame;
  logic       cmd_hit;

  assign raw_in = {din, cs_n, sclk};

  rd_sync #(.N(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw_in), .lvl(sync_out)
  );
  assign sclk_s = sync_out[0];
  assign cs_s   = sync_out[1];
  assign din_s  = sync_out[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_rise   = cs_s & ~cs_d;
  assign in_frame  = ~cs_s;

  rd_cmd_sniff #(.RDATA_OP(RDATA_OP), .RREG_VAL(RREG_VAL), .RREG_MASK(RREG_MASK)) u_sniff (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .sclk_rise(sclk_rise),
    .din_s(din_s), .cmd_hit(cmd_hit)
  );

  rd_word_path #(.WORD_W(WORD_W), .KEEP_BITS(KEEP_BITS)) u_path (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .conv_valid(conv_valid), .conv_word(conv_word),
    .reload_req(reload_req), .abort(cmd_hit), .dout_bit(dout), .drdy_n(drdy_n)
  );

  assign dout_en  = ~cs_n;
  assign cmd_pend = cmd_hit;

  // R11: nothing pending or ready straight after reset
  assert_reset_idle_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> (drdy_n && !cmd_pend));
endmodule

// File: tb/sim_conv_readout.sv
module sim_conv_readout;
  localparam int CLK_PER = 10;

  logic        clk = 0, rst_n = 0;
  logic        conv_valid = 0, reload_req = 0;
  logic [31:0] conv_word = '0;
  logic        sclk = 0, cs_n = 1, din = 0;
  logic        dout, dout_en, drdy_n, cmd_pend;

  int nvec = 0, nfail = 0, npulse = 0;
  logic [31:0] txw = '0;
  logic [63:0] rx = '0;

  always #(CLK_PER/2) clk = ~clk;

  conv_readout u0 (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_word(conv_word),
    .reload_req(reload_req), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_en(dout_en), .drdy_n(drdy_n), .cmd_pend(cmd_pend)
  );

  always @(posedge clk) if (rst_n && cmd_pend) npulse <= npulse + 1;

  function automatic logic [31:0] abort_view(input logic [31:0] w);
    return {w[31:24], 24'h0};
  endfunction

  function automatic logic is_cmd(input logic [7:0] b);
    return (b == 8'h12) || (b[7:5] == 3'b001);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] w);
    @(negedge clk); conv_valid = 1; conv_word = w;
    @(negedge clk); conv_valid = 0;
  endtask

  task automatic reload();
    @(negedge clk); reload_req = 1;
    @(negedge clk); reload_req = 0;
  endtask

  task automatic cs_lo(input logic [31:0] held, input logic chk_msb);
    @(negedge clk); cs_n = 0; din = txw[31];
    #1;
    chk("R1 enable on cs low", {63'd0, dout_en}, 64'd1);
    if (chk_msb) chk("R1 msb before sclk", {63'd0, dout}, {63'd0, held[31]});
    wclk(5);
  endtask

  task automatic cs_hi();
    @(negedge clk); cs_n = 1; din = 0;
    #1;
    chk("R1 release on cs high", {63'd0, dout_en}, 64'd0);
    wclk(6);
  endtask

  int bitpos = 0;
  task automatic clk_bits(input int n);
    for (int i = 0; i < n; i++) begin
      din = (bitpos < 32) ? txw[31-bitpos] : 1'b0;
      wclk(5);
      rx = {rx[62:0], dout};
      sclk = 1;
      wclk(5);
      sclk = 0;
      bitpos++;
    end
    wclk(5);
  endtask

  task automatic frame32(input logic [31:0] held, input logic chk_msb);
    bitpos = 0;
    cs_lo(held, chk_msb);
    clk_bits(32);
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] w1, w2;
    int base, k;
    void'($urandom(32'd4711));
    wclk(5);
    rst_n = 1;
    wclk(2);
    chk("R11 drdy_n after reset", {63'd0, drdy_n}, 64'd1);
    chk("R11 cmd_pend after reset", {63'd0, cmd_pend}, 64'd0);
    chk("R1 idle released", {63'd0, dout_en}, 64'd0);

    // basic read, zero fill
    w1 = 32'hA5C3_1E77;
    load(w1);
    chk("R3 drdy_n low on load", {63'd0, drdy_n}, 64'd0);
    bitpos = 0;
    cs_lo(w1, 1);
    clk_bits(1);
    chk("R3 drdy_n high after first fall", {63'd0, drdy_n}, 64'd1);
    clk_bits(31);
    chk("R4 R2 word msb first", {32'd0, rx[31:0]}, {32'd0, w1});
    clk_bits(4);
    chk("R4 zero fill", {60'd0, rx[3:0]}, 64'd0);
    cs_hi();

    // second direct read gives nothing
    frame32(32'd0, 1);
    chk("R9 repeat read zeros", {32'd0, rx[31:0]}, 64'd0);

    // reload
    reload();
    chk("R8 reload keeps drdy_n", {63'd0, drdy_n}, 64'd1);
    frame32(w1, 1);
    chk("R8 reload word", {32'd0, rx[31:0]}, {32'd0, w1});

    // mid-frame chip select raise
    w2 = 32'h3C96_0F5A;
    load(w2);
    bitpos = 0;
    cs_lo(w2, 1);
    clk_bits(8);
    cs_hi();
    chk("R10 partial byte", {56'd0, rx[7:0]}, {56'd0, w2[31:24]});
    reload();
    frame32(w2, 1);
    chk("R10 restart from msb", {32'd0, rx[31:0]}, {32'd0, w2});

    // early result dropped (23 bits out)
    w1 = 32'h1234_5678; w2 = 32'hFEDC_BA98;
    load(w1);
    bitpos = 0;
    cs_lo(w1, 1);
    clk_bits(23);
    load(w2);
    clk_bits(9);
    chk("R5 current read intact", {32'd0, rx[31:0]}, {32'd0, w1});
    cs_hi();
    chk("R5 drdy_n stays high", {63'd0, drdy_n}, 64'd1);
    frame32(32'd0, 0);
    chk("R5 dropped word absent", {32'd0, rx[31:0]}, 64'd0);

    // late result kept (24 bits out)
    load(w1);
    bitpos = 0;
    cs_lo(w1, 1);
    clk_bits(24);
    load(w2);
    chk("R6 drdy_n high during frame", {63'd0, drdy_n}, 64'd1);
    clk_bits(8);
    chk("R6 current read intact", {32'd0, rx[31:0]}, {32'd0, w1});
    cs_hi();
    chk("R6 drdy_n low after cs rise", {63'd0, drdy_n}, 64'd0);
    frame32(w2, 1);
    chk("R6 kept word read", {32'd0, rx[31:0]}, {32'd0, w2});

    // command bytes on din
    w1 = 32'hC0FF_EE11;
    load(w1);
    txw = {8'h12, 24'h0};
    base = npulse;
    frame32(w1, 1);
    chk("R7 read-data pulse count", 64'(npulse - base), 64'(is_cmd(8'h12)));
    chk("R7 read-data abort", {32'd0, rx[31:0]}, {32'd0, abort_view(w1)});

    load(w1);
    txw = {8'h2B, 24'h0};
    base = npulse;
    frame32(w1, 1);
    chk("R7 read-register pulse count", 64'(npulse - base), 64'(is_cmd(8'h2B)));
    chk("R7 read-register abort", {32'd0, rx[31:0]}, {32'd0, abort_view(w1)});

    load(w1);
    txw = 32'hA5A5_A5A5;
    base = npulse;
    frame32(w1, 1);
    chk("R7 other byte no pulse", 64'(npulse - base), 64'd0);
    chk("R7 other byte no effect", {32'd0, rx[31:0]}, {32'd0, w1});
    txw = '0;

    // random words with a result arriving at a random point
    for (int it = 0; it < 25; it++) begin
      w1 = $urandom; w2 = $urandom;
      k = $urandom_range(31, 1);
      load(w1);
      bitpos = 0;
      cs_lo(w1, 1);
      clk_bits(k);
      load(w2);
      clk_bits(32 - k);
      chk("R4 random word", {32'd0, rx[31:0]}, {32'd0, w1});
      cs_hi();
      if (k >= 24) begin
        chk("R6 random late kept", {63'd0, drdy_n}, 64'd0);
        frame32(w2, 1);
        chk("R6 random late word", {32'd0, rx[31:0]}, {32'd0, w2});
      end else begin
        chk("R5 random early dropped", {63'd0, drdy_n}, 64'd1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule